// File: doc/BRIEF.md
# Memory Word ECC Codec with Adjacent-Pair Correction

This block protects a 32-bit memory word with 7 check bits, giving a 39-bit stored word. The encoder side is purely combinational: it takes the 32 data bits and returns the full word, with data in positions 0 to 31 and check bits in positions 32 to 38. The decoder side accepts a possibly damaged 39-bit word together with a valid strobe. One clock later it presents the repaired data, two status flags and the raw 7-bit syndrome.

Every column of the check matrix has odd weight. As a result, any one flipped bit gives an odd-weight syndrome and any two flipped bits give an even-weight, nonzero syndrome. The columns are chosen by a deterministic search during elaboration. The search makes the syndromes of the 38 physically neighbouring bit pairs distinct from each other. The decoder therefore repairs a single flipped bit, and also repairs two flipped bits that sit next to each other. Any other nonzero syndrome is reported as uncorrectable.

Some non-neighbouring double errors share a syndrome with a neighbouring pair. These are repaired wrongly. This is an accepted property of the code.

Top module: `ecc_codec`

## Requirements
- R1: A word produced by the encoder and decoded without damage returns the original data, a zero syndrome, and both flags low.
- R2: The decoder result appears exactly one clock after an input carrying the valid strobe, with the output valid high in that cycle. When no valid input arrives, the output valid goes low and the data, flags and syndrome outputs keep their previous values.
- R3: Flipping any one of the 39 word bits yields the original data, with the corrected flag high and the uncorrectable flag low.
- R4: The syndrome of each single flipped bit has odd weight, and the 39 positions give 39 different syndromes.
- R5: Flipping two neighbouring bits (positions i and i+1, for i from 0 to 37) yields the original data, with the corrected flag high and the uncorrectable flag low.
- R6: Flipping two non-neighbouring bits gives a nonzero, even-weight syndrome and always raises at least one flag. The uncorrectable flag is never raised with a zero syndrome.
- R7: The corrected flag and the uncorrectable flag are never high together.
- R8: While reset is held (active low), the output valid, both flags and the syndrome output are zero.
- R9: The encoded word carries the data unchanged in bits 0 to 31, with check bits in bits 32 to 38.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous to clk |
| encData | input | 32 | Data to encode |
| encWord | output | 39 | Encoded word: data bits 0-31, check bits 32-38 |
| decValid | input | 1 | Strobe marking decWord as a word to decode |
| decWord | input | 39 | Stored word to check and repair |
| outValid | output | 1 | High one cycle after decValid |
| outData | output | 32 | Repaired data |
| outCorrected | output | 1 | An error was found and repaired |
| outUncorrectable | output | 1 | Nonzero syndrome that matches no repairable pattern |
| outSyndrome | output | 7 | Raw syndrome of the decoded word |

## Verification
The bench builds the codec with its default widths: 32 data bits and 7 check bits. At these widths, an exhaustive sweep over every single-bit error and every one of the 741 two-bit error placements is affordable for each test word. The sweep is repeated over all-zero, all-one, alternating and seeded random data words. This exposes every column, every neighbouring-pair syndrome, and each non-neighbouring pair that aliases onto a pair entry; the aliased cases are counted as miscorrections rather than treated as faults.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int DATA_W = 32;
  localparam int CHK_W  = 7;
  localparam int WORD_W = DATA_W + CHK_W;
  localparam int PAIR_N = WORD_W - 1;
  localparam int SYN_N  = 1 << CHK_W;

  typedef logic [WORD_W-1:0][CHK_W-1:0] colTab_t;

  typedef struct packed {
    logic loadResult;
  } ctrlStrobe_t;

  // Greedy column search: odd-weight columns, check bits get unit columns,
  // every neighbouring-pair XOR must be fresh.
  function automatic colTab_t buildColumns();
    colTab_t t;
    logic [SYN_N-1:0] usedCol;
    logic [SYN_N-1:0] usedPair;
    logic found;
    logic ok;
    t = '0;
    usedCol = '0;
    usedPair = '0;
    for (int k = 0; k < CHK_W; k++) begin
      t[DATA_W+k] = CHK_W'(1 << k);
      usedCol[1 << k] = 1'b1;
    end
    for (int k = 0; k < CHK_W - 1; k++) begin
      usedPair[(1 << k) | (1 << (k + 1))] = 1'b1;
    end
    for (int i = 0; i < DATA_W; i++) begin
      found = 1'b0;
      for (int v = 3; v < SYN_N; v++) begin
        if (!found && ($countones(v) % 2 == 1) && !usedCol[v]) begin
          ok = 1'b1;
          if (i > 0) begin
            if (usedPair[v ^ int'(t[i-1])]) ok = 1'b0;
          end
          if (i == DATA_W - 1) begin
            if (usedPair[v ^ 1]) ok = 1'b0;
          end
          if (ok) begin
            t[i] = CHK_W'(v);
            usedCol[v] = 1'b1;
            if (i > 0) usedPair[v ^ int'(t[i-1])] = 1'b1;
            if (i == DATA_W - 1) usedPair[v ^ 1] = 1'b1;
            found = 1'b1;
          end
        end
      end
    end
    return t;
  endfunction

  localparam colTab_t COLS = buildColumns();
endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_pkg::*;
(
  input  logic [DATA_W-1:0] dataIn,
  output logic [WORD_W-1:0] wordOut
);
  logic [CHK_W-1:0] checkBits;

  always_comb begin
    checkBits = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (dataIn[i]) checkBits = checkBits ^ COLS[i];
    end
  end

  assign wordOut = {checkBits, dataIn};
endmodule

// File: rtl/ecc_ctrl.sv
module ecc_ctrl
  import ecc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output ctrlStrobe_t strobe,
  output logic        outValid
);
  logic validQ;

  assign strobe.loadResult = inValid;

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= inValid;
  end

  assign outValid = validQ;

  // R2: one-cycle latency of the valid strobe
  p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/ecc_datapath.sv
module ecc_datapath
  import ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [WORD_W-1:0] wordIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              corrOut,
  output logic              uncorrOut,
  output logic [CHK_W-1:0]  synOut
);
  logic [CHK_W-1:0]  syn;
  logic [WORD_W-1:0] hitSingle;
  logic [PAIR_N-1:0] hitPair;
  logic [WORD_W-1:0] flipMask;
  logic              matched;
  logic              nonZero;

  always_comb begin
    syn = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (wordIn[i]) syn = syn ^ COLS[i];
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < WORD_W; gi++) begin : g_single
      assign hitSingle[gi] = (syn == COLS[gi]);
    end
    for (gi = 0; gi < PAIR_N; gi++) begin : g_pair
      assign hitPair[gi] = (syn == (COLS[gi] ^ COLS[gi+1]));
    end
    for (gi = 0; gi < WORD_W; gi++) begin : g_mask
      if (gi == 0) begin : g_first
        assign flipMask[gi] = hitSingle[gi] | hitPair[gi];
      end else if (gi == WORD_W - 1) begin : g_last
        assign flipMask[gi] = hitSingle[gi] | hitPair[gi-1];
      end else begin : g_mid
        assign flipMask[gi] = hitSingle[gi] | hitPair[gi] | hitPair[gi-1];
      end
    end
  endgenerate

  assign nonZero = |syn;
  assign matched = (|hitSingle) | (|hitPair);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut   <= '0;
      corrOut   <= 1'b0;
      uncorrOut <= 1'b0;
      synOut    <= '0;
    end else if (strobe.loadResult) begin
      dataOut   <= wordIn[DATA_W-1:0] ^ flipMask[DATA_W-1:0];
      corrOut   <= nonZero & matched;
      uncorrOut <= nonZero & ~matched;
      synOut    <= syn;
    end
  end

  // R7: flags are mutually exclusive
  p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(corrOut && uncorrOut));
  // R1: zero syndrome reports a clean word
  p_zero_syn_clean_r1: assert property (@(posedge clk) disable iff (!rstN)
    (synOut == '0) |-> (!corrOut && !uncorrOut));
  // R6: uncorrectable never with zero syndrome
  p_uncorr_nonzero_r6: assert property (@(posedge clk) disable iff (!rstN)
    uncorrOut |-> (synOut != '0));
  // R2: outputs hold when nothing is loaded
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadResult |=> ($stable(dataOut) && $stable(synOut) && $stable(corrOut)));
  // R4: a single-column match always has odd syndrome weight
  p_single_odd_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|hitSingle) |-> ($countones(syn) % 2 == 1));
  // R5: neighbouring-pair matches are unique
  p_pair_unique_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitPair));
endmodule

// File: rtl/ecc_codec.sv
module ecc_codec
  import ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] encData,
  output logic [WORD_W-1:0] encWord,
  input  logic              decValid,
  input  logic [WORD_W-1:0] decWord,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outCorrected,
  output logic              outUncorrectable,
  output logic [CHK_W-1:0]  outSyndrome
);
  ctrlStrobe_t strobe;

  ecc_encoder u_enc (
    .dataIn  (encData),
    .wordOut (encWord)
  );

  ecc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (decValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  ecc_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wordIn    (decWord),
    .dataOut   (outData),
    .corrOut   (outCorrected),
    .uncorrOut (outUncorrectable),
    .synOut    (outSyndrome)
  );
endmodule

// File: tb/sim_ecc_codec.sv
module sim_ecc_codec;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int WW = 39;
  localparam int CW = 7;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [DW-1:0] encData = '0;
  logic [WW-1:0] encWord;
  logic          decValid = 1'b0;
  logic [WW-1:0] decWord = '0;
  logic          outValid;
  logic [DW-1:0] outData;
  logic          outCorrected;
  logic          outUncorrectable;
  logic [CW-1:0] outSyndrome;

  int tests = 0;
  int fails = 0;
  int miscorr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_codec u0 (
    .clk(clk), .rstN(rstN), .encData(encData), .encWord(encWord),
    .decValid(decValid), .decWord(decWord), .outValid(outValid),
    .outData(outData), .outCorrected(outCorrected),
    .outUncorrectable(outUncorrectable), .outSyndrome(outSyndrome)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit isOdd(input logic [CW-1:0] s);
    return ($countones(s) % 2) == 1;
  endfunction

  // called at a negedge; returns at the next negedge with the result visible
  task automatic sendWord(input logic [WW-1:0] w);
    decWord = w;
    decValid = 1'b1;
    @(negedge clk);
  endtask

  task automatic runWord(input logic [DW-1:0] d);
    logic [WW-1:0] cw;
    logic [CW-1:0] seen [WW];
    int dup;
    encData = d;
    #1;
    cw = encWord;
    chk(cw[DW-1:0] == d, "R9 data bits in place", 64'(cw[DW-1:0]), 64'(d));
    @(negedge clk);
    sendWord(cw);
    chk(outData == d && outSyndrome == '0 && !outCorrected && !outUncorrectable,
        "R1 clean decode", {outCorrected, outUncorrectable, outSyndrome, outData}, 64'(d));
    for (int i = 0; i < WW; i++) begin
      sendWord(cw ^ (WW'(1) << i));
      seen[i] = outSyndrome;
      chk(outData == d && outCorrected && !outUncorrectable, "R3 single repair",
          {outCorrected, outUncorrectable, outData}, {2'b10, d});
      chk(isOdd(outSyndrome), "R4 odd single syndrome", 64'(outSyndrome), 64'(i));
    end
    dup = 0;
    for (int i = 0; i < WW; i++)
      for (int j = i + 1; j < WW; j++)
        if (seen[i] == seen[j]) dup++;
    chk(dup == 0, "R4 distinct single syndromes", 64'(dup), 64'(0));
    for (int i = 0; i < WW; i++) begin
      for (int j = i + 1; j < WW; j++) begin
        sendWord(cw ^ (WW'(1) << i) ^ (WW'(1) << j));
        chk(!(outCorrected && outUncorrectable), "R7 flags exclusive",
            {outCorrected, outUncorrectable}, 64'(0));
        if (j == i + 1) begin
          chk(outData == d && outCorrected && !outUncorrectable, "R5 neighbour pair repair",
              {outCorrected, outUncorrectable, outData}, {2'b10, d});
        end else begin
          chk(outSyndrome != '0 && !isOdd(outSyndrome), "R6 even nonzero syndrome",
              64'(outSyndrome), 64'(0));
          chk(outCorrected || outUncorrectable, "R6 double flagged",
              {outCorrected, outUncorrectable}, 64'(1));
          if (outCorrected) miscorr++;
        end
      end
    end
  endtask

  initial begin
    logic [DW-1:0] held;
    logic [CW-1:0] heldSyn;
    void'($urandom(32'h5EC0DAEC));
    repeat (3) @(negedge clk);
    chk(!outValid && !outCorrected && !outUncorrectable && outSyndrome == '0,
        "R8 reset state", {outValid, outCorrected, outUncorrectable, outSyndrome}, 64'(0));
    rstN = 1'b1;
    @(negedge clk);
    // R2 latency and hold
    encData = 32'hDEADBEEF;
    #1;
    decWord = encWord ^ (WW'(1) << 5);
    decValid = 1'b1;
    chk(!outValid, "R2 valid low before strobe", 64'(outValid), 64'(0));
    @(negedge clk);
    chk(outValid && outData == 32'hDEADBEEF, "R2 result after one cycle",
        {outValid, outData}, {1'b1, 32'hDEADBEEF});
    held = outData;
    heldSyn = outSyndrome;
    decValid = 1'b0;
    decWord = '1;
    @(negedge clk);
    chk(!outValid && outData == held && outSyndrome == heldSyn, "R2 hold when idle",
        {outValid, outSyndrome, outData}, {1'b0, heldSyn, held});
    runWord(32'h0000_0000);
    runWord(32'hFFFF_FFFF);
    runWord(32'hA5A5_5A5A);
    for (int k = 0; k < 3; k++) runWord($urandom);
    $display("[TB] info: %0d non-neighbour doubles miscorrected", miscorr);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule